// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a logical address, given as a segment number plus an offset, into a physical address. It does so with a small segment table held in registers. Each table entry holds a starting physical address (base), a segment length (limit), a valid flag and three permission flags (read, write, execute). A separate length register tells how many table entries are in use. For each lookup the unit computes base plus offset. In parallel it runs four protection checks: segment number against the length register, the entry's valid flag, offset against limit, and the access type against the permission flags. When any check fails it reports the highest-priority fault instead of an address.

Software fills the table and sets the length register through a synchronous write port, one entry per clock. A lookup is presented on the inputs in one cycle. Its result (address, fault flag, fault code) appears on registered outputs after the next rising clock edge, and a new lookup can be presented every cycle.

Top module: `seg_xlat_unit`

## Requirements
- R1: After a synchronous active-low reset, the outputs are zero with no fault, the length register is 0 and every table entry is invalid, so any lookup then reports fault code 1.
- R2: A lookup that passes all checks yields, one clock edge later, a physical address equal to base plus zero-extended offset, modulo 2^24, with fault flag 0 and fault code 0.
- R3: A segment number greater than or equal to the length register (including numbers 16 and above) gives fault code 1 (segment out of range).
- R4: An in-range segment whose entry has its valid flag at 0 gives fault code 2 (invalid segment).
- R5: An offset greater than or equal to the entry's limit gives fault code 3 (limit exceeded); a limit of 0 therefore faults on every offset.
- R6: Access code 0 (read) needs permission bit 0, code 1 (write) needs bit 1, and code 2 (execute) needs bit 2. Code 3 is always refused. A refusal gives fault code 4 (permission).
- R7: When several checks fail, only one fault is reported, in the priority order code 1, then 2, then 3, then 4.
- R8: On any fault the physical address output is 0 and the fault flag is 1. Without a fault the flag is 0 and the code is 0.
- R9: A length write larger than 16 stores 16.
- R10: Table and length writes take effect at the clock edge. A lookup presented in the same cycle as a write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_i | input | 5 | Segment number of the lookup |
| off_i | input | 16 | Offset of the lookup |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| wr_en_i | input | 1 | Write one table entry |
| wr_idx_i | input | 4 | Entry index to write |
| wr_base_i | input | 24 | Base for the written entry |
| wr_lim_i | input | 16 | Limit for the written entry |
| wr_vld_i | input | 1 | Valid flag for the written entry |
| wr_perm_i | input | 3 | Permission flags {execute, write, read} |
| len_we_i | input | 1 | Write the length register |
| len_i | input | 5 | New length value (saturated to 16) |
| pa_o | output | 24 | Physical address, 0 on a fault |
| fault_o | output | 1 | Fault flag |
| fault_code_o | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 permission |

## Verification
A corrupted table field or length value does not show until a lookup touches that entry. When one does, the error appears one edge later as a wrong address or a wrong fault code. The bench therefore keeps looking up every entry, at offsets around each limit, while writes continue. A wrong priority shows only when two checks fail together, so the directed part builds entries that fail several checks at once. The random part keeps mixing table rewrites with lookups, so a stale read or a missed write shows within a few cycles of the write.

// File: rtl/seg_xlat_pkg.sv
// Shared types for the segment translation unit.
// Assumes: fault codes and access codes are part of the external contract.
package seg_xlat_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } flt_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    localparam int PERM_RD_BIT = 0;
    localparam int PERM_WR_BIT = 1;
    localparam int PERM_EX_BIT = 2;
    localparam int PERM_W      = 3;

endpackage

// File: rtl/seg_table.sv
// Segment table storage plus the in-use length register.
// Does: holds ENTRIES records {valid, perm, limit, base}, written one per
// clock; reads are asynchronous by index. Length writes saturate at ENTRIES.
// Assumes: synchronous active-low reset clears every record and the length.
module seg_table #(
    parameter int ENTRIES = 16,
    parameter int BASE_W  = 24,
    parameter int LIM_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int LEN_W   = $clog2(ENTRIES + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [BASE_W-1:0]                wr_base,
    input  logic [LIM_W-1:0]                 wr_lim,
    input  logic                             wr_vld,
    input  logic [seg_xlat_pkg::PERM_W-1:0]  wr_perm,
    input  logic                             len_we,
    input  logic [LEN_W-1:0]                 len_in,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [BASE_W-1:0]                rd_base,
    output logic [LIM_W-1:0]                 rd_lim,
    output logic                             rd_vld,
    output logic [seg_xlat_pkg::PERM_W-1:0]  rd_perm,
    output logic [LEN_W-1:0]                 len_q
);
    import seg_xlat_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(ENTRIES);

    logic [BASE_W-1:0] base_q [ENTRIES];
    logic [LIM_W-1:0]  lim_q  [ENTRIES];
    logic [PERM_W-1:0] perm_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    // Purpose: store one record on a write strobe, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx]  <= wr_vld;
            base_q[wr_idx] <= wr_base;
            lim_q[wr_idx]  <= wr_lim;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // Purpose: hold the in-use count, saturated to the table size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we) begin
            len_q <= (len_in > LEN_MAX) ? LEN_MAX : len_in;
        end
    end

    // Purpose: asynchronous read of the addressed record.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_lim  = lim_q[rd_idx];
        rd_perm = perm_q[rd_idx];
        rd_vld  = vld_q[rd_idx];
    end

    // R9
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_MAX);

    // R10
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base))
               && (vld_q[$past(wr_idx)] == $past(wr_vld)));

endmodule

// File: rtl/seg_check.sv
// Protection checker: picks the single highest-priority fault.
// Does: range, valid, limit and permission tests in fixed priority order.
// Assumes: the record inputs are those of the looked-up segment and the
// length never exceeds the table size.
module seg_check #(
    parameter int SEG_W = 5,
    parameter int LEN_W = 5,
    parameter int OFF_W = 16,
    parameter int LIM_W = 16
) (
    input  logic [SEG_W-1:0]                 seg,
    input  logic [LEN_W-1:0]                 len,
    input  logic                             vld,
    input  logic [LIM_W-1:0]                 lim,
    input  logic [seg_xlat_pkg::PERM_W-1:0]  perm,
    input  logic [OFF_W-1:0]                 off,
    input  seg_xlat_pkg::acc_e               acc,
    output seg_xlat_pkg::flt_e               flt
);
    import seg_xlat_pkg::*;

    localparam int RW = (SEG_W > LEN_W) ? SEG_W : LEN_W;
    localparam int CW = (OFF_W > LIM_W) ? OFF_W : LIM_W;

    logic in_range;
    logic in_limit;
    logic allowed;

    // Purpose: width-neutral range and limit comparisons.
    always_comb begin
        in_range = RW'(seg) < RW'(len);
        in_limit = CW'(off) < CW'(lim);
    end

    // Purpose: match the access type to its permission bit.
    always_comb begin
        unique case (acc)
            ACC_RD:  allowed = perm[PERM_RD_BIT];
            ACC_WR:  allowed = perm[PERM_WR_BIT];
            ACC_EX:  allowed = perm[PERM_EX_BIT];
            default: allowed = 1'b0;
        endcase
    end

    // Purpose: report only the first failing check in priority order.
    always_comb begin
        if (!in_range)      flt = FLT_RANGE;
        else if (!vld)      flt = FLT_INVALID;
        else if (!in_limit) flt = FLT_LIMIT;
        else if (!allowed)  flt = FLT_PERM;
        else                flt = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlat_unit.sv
// Segment translation top: table lookup, base+offset add, protection
// check and registered result.
// Does: one lookup per cycle, result valid after the next clock edge.
// Assumes: SEG_W >= index width so the low bits index the table; segment
// numbers above the table size are caught by the length check.
module seg_xlat_unit #(
    parameter int ENTRIES = 16,
    parameter int SEG_W   = 5,
    parameter int OFF_W   = 16,
    parameter int BASE_W  = 24,
    parameter int LIM_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int LEN_W   = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        acc_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BASE_W-1:0] wr_base_i,
    input  logic [LIM_W-1:0]  wr_lim_i,
    input  logic              wr_vld_i,
    input  logic [2:0]        wr_perm_i,
    input  logic              len_we_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [BASE_W-1:0] pa_o,
    output logic              fault_o,
    output logic [2:0]        fault_code_o
);
    import seg_xlat_pkg::*;

    localparam int RW = (SEG_W > LEN_W) ? SEG_W : LEN_W;
    localparam int CW = (OFF_W > LIM_W) ? OFF_W : LIM_W;

    logic [BASE_W-1:0] rd_base;
    logic [LIM_W-1:0]  rd_lim;
    logic              rd_vld;
    logic [PERM_W-1:0] rd_perm;
    logic [LEN_W-1:0]  tbl_len;
    logic [BASE_W-1:0] sum;
    flt_e              flt;

    seg_table #(
        .ENTRIES (ENTRIES), .BASE_W (BASE_W), .LIM_W (LIM_W),
        .IDX_W (IDX_W), .LEN_W (LEN_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_idx  (wr_idx_i),
        .wr_base (wr_base_i),
        .wr_lim  (wr_lim_i),
        .wr_vld  (wr_vld_i),
        .wr_perm (wr_perm_i),
        .len_we  (len_we_i),
        .len_in  (len_i),
        .rd_idx  (seg_i[IDX_W-1:0]),
        .rd_base (rd_base),
        .rd_lim  (rd_lim),
        .rd_vld  (rd_vld),
        .rd_perm (rd_perm),
        .len_q   (tbl_len)
    );

    seg_check #(
        .SEG_W (SEG_W), .LEN_W (LEN_W), .OFF_W (OFF_W), .LIM_W (LIM_W)
    ) u_check (
        .seg  (seg_i),
        .len  (tbl_len),
        .vld  (rd_vld),
        .lim  (rd_lim),
        .perm (rd_perm),
        .off  (off_i),
        .acc  (acc_e'(acc_i)),
        .flt  (flt)
    );

    // Purpose: relocate the offset by the segment base, wrapping.
    always_comb begin
        sum = rd_base + BASE_W'(off_i);
    end

    // Purpose: register the result; a fault forces the address to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_o         <= '0;
            fault_o      <= 1'b0;
            fault_code_o <= FLT_NONE;
        end else begin
            pa_o         <= (flt == FLT_NONE) ? sum : '0;
            fault_o      <= (flt != FLT_NONE);
            fault_code_o <= flt;
        end
    end

    // R3
    range_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RW'(seg_i) >= RW'(tbl_len)) |=> (fault_code_o == FLT_RANGE));

    // R4
    invalid_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((RW'(seg_i) < RW'(tbl_len)) && !rd_vld) |=> (fault_code_o == FLT_INVALID));

    // R5
    limit_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((RW'(seg_i) < RW'(tbl_len)) && rd_vld && (CW'(off_i) >= CW'(rd_lim)))
        |=> (fault_code_o == FLT_LIMIT));

    // R8
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (pa_o == '0));

    // R8
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == (fault_code_o != FLT_NONE));

endmodule

// File: tb/seg_xlat_unit_bench.sv
// Bench: behavioural table model, one comparison per clock.
module seg_xlat_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  seg = '0;
    logic [15:0] off = '0;
    logic [1:0]  acc = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [23:0] wr_base = '0;
    logic [15:0] wr_lim = '0;
    logic        wr_vld = 1'b0;
    logic [2:0]  wr_perm = '0;
    logic        len_we = 1'b0;
    logic [4:0]  len_v = '0;
    logic [23:0] pa;
    logic        flt;
    logic [2:0]  code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] m_base [16];
    logic [15:0] m_lim  [16];
    logic [2:0]  m_perm [16];
    bit          m_vld  [16];
    int          m_len;

    seg_xlat_unit u_seg_xlat_unit (
        .clk (clk), .rst_n (rst_n), .seg_i (seg), .off_i (off), .acc_i (acc),
        .wr_en_i (wr_en), .wr_idx_i (wr_idx), .wr_base_i (wr_base),
        .wr_lim_i (wr_lim), .wr_vld_i (wr_vld), .wr_perm_i (wr_perm),
        .len_we_i (len_we), .len_i (len_v),
        .pa_o (pa), .fault_o (flt), .fault_code_o (code)
    );

    always #4 clk = ~clk;

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0; m_vld[i] = 0;
        end
        m_len = 0;
    endtask

    // One clock: predict, advance the model, clock, compare at the negedge.
    task automatic tick(input string tag);
        int          e_code;
        logic [23:0] e_pa;
        string       t;
        e_code = 0;
        e_pa   = '0;
        if (!rst_n) begin
            model_clear();
        end else begin
            if (int'(seg) >= m_len)              e_code = 1;
            else if (!m_vld[seg[3:0]])           e_code = 2;
            else if (off >= m_lim[seg[3:0]])     e_code = 3;
            else if (acc == 2'd3 || !m_perm[seg[3:0]][acc]) e_code = 4;
            if (e_code == 0) e_pa = 24'(m_base[seg[3:0]] + 24'(off));
            if (wr_en) begin
                m_base[wr_idx] = wr_base; m_lim[wr_idx] = wr_lim;
                m_perm[wr_idx] = wr_perm; m_vld[wr_idx] = wr_vld;
            end
            if (len_we) m_len = (int'(len_v) > 16) ? 16 : int'(len_v);
        end
        @(posedge clk);
        @(negedge clk);
        t = tag;
        if (t == "") begin
            case (e_code)
                0: t = "R2"; 1: t = "R3"; 2: t = "R4"; 3: t = "R5"; default: t = "R6";
            endcase
        end
        checks++;
        if (pa !== e_pa || code !== 3'(e_code) || flt !== (e_code != 0)) begin
            errors++;
            $display("FAIL %s: pa=%h code=%0d flag=%b expected pa=%h code=%0d flag=%b",
                     t, pa, code, flt, e_pa, e_code, (e_code != 0));
        end
        wr_en = 1'b0;
        len_we = 1'b0;
    endtask

    task automatic put(input int idx, input logic [23:0] b, input logic [15:0] l,
                       input bit v, input logic [2:0] p);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_base = b; wr_lim = l;
        wr_vld = v; wr_perm = p;
        tick("R10");
    endtask

    task automatic set_len(input int n);
        len_we = 1'b1; len_v = 5'(n);
        tick("R9");
    endtask

    task automatic look(input int s, input int o, input int a, input string tag);
        seg = 5'(s); off = 16'(o); acc = 2'(a);
        tick(tag);
    endtask

    initial begin
        model_clear();
        rst_n = 1'b0;
        repeat (3) tick("R1");
        rst_n = 1'b1;
        // R1: empty table after reset
        look(0, 0, 0, "R1");
        look(3, 5, 1, "R1");

        set_len(4);
        put(0, 24'h001000, 16'd256, 1, 3'b111);
        put(1, 24'hFFFF00, 16'h1000, 1, 3'b001);
        put(2, 24'h050000, 16'd10, 0, 3'b111);
        put(3, 24'h070000, 16'd0, 1, 3'b111);
        put(5, 24'h090000, 16'd100, 1, 3'b111);

        // R2: plain translation and wrap past 2^24
        look(0, 16'h0010, 0, "R2");
        look(0, 255, 2, "R2");
        look(1, 16'h0200, 0, "R2");
        // R5: limit boundary and zero limit
        look(0, 256, 0, "R5");
        look(0, 65535, 0, "R5");
        look(3, 0, 0, "R5");
        // R4: invalid entry
        look(2, 0, 0, "R4");
        // R6: each access type, reserved code refused
        look(1, 4, 1, "R6");
        look(1, 4, 2, "R6");
        look(0, 4, 3, "R6");
        // R3: range, including numbers beyond the table
        look(4, 0, 0, "R3");
        look(20, 0, 0, "R3");
        // R7: several failures at once
        look(5, 500, 3, "R7");
        look(2, 500, 3, "R7");
        look(1, 16'h2000, 1, "R7");
        // R8: fault forces zero address
        look(1, 0, 2, "R8");
        // R9: length saturation
        put(15, 24'h123456, 16'd50, 1, 3'b100);
        set_len(31);
        look(15, 49, 2, "R9");
        look(16, 0, 0, "R9");
        // R10: lookup during write sees old data, then new
        seg = 5'd0; off = 16'd1; acc = 2'd0;
        wr_en = 1'b1; wr_idx = 4'd0; wr_base = 24'h400000;
        wr_lim = 16'd8; wr_vld = 1'b1; wr_perm = 3'b001;
        tick("R10");
        look(0, 1, 0, "R10");
        look(0, 8, 0, "R10");

        // Random mix of writes and lookups
        for (int n = 0; n < 400; n++) begin
            seg = 5'($urandom_range(0, 18));
            acc = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) off = 16'($urandom);
            else off = 16'(int'(m_lim[seg[3:0]]) + $urandom_range(0, 4) - 2);
            if ($urandom_range(0, 4) == 0) begin
                wr_en = 1'b1; wr_idx = 4'($urandom_range(0, 15));
                wr_base = 24'($urandom); wr_lim = 16'($urandom_range(0, 300));
                wr_vld = ($urandom_range(0, 3) != 0); wr_perm = 3'($urandom);
            end
            if ($urandom_range(0, 29) == 0) begin
                len_we = 1'b1; len_v = 5'($urandom_range(0, 20));
            end
            tick("");
        end

        // R1: reset again in mid-run clears table and length
        rst_n = 1'b0;
        tick("R1");
        rst_n = 1'b1;
        look(0, 0, 0, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule